// File: doc/BRIEF.md
# Pulse-Width DAC Bank with Rate Multiplier

This block holds sixteen pulse-width output channels. Each channel turns an 8-bit value into a digital waveform whose average level acts as an 8-bit DAC. All channels share one free-running 8-bit counter. The lower five counter bits count the clocks inside a 32-clock period. The upper three bits count the periods inside a frame of eight periods.

The upper five bits of a channel value set how many clocks at the start of each period the output is high. The lower three bits feed a binary rate multiplier. In the periods that the multiplier picks, the high time is one clock longer. Those extra clocks are spread evenly across the frame, so the output is high for exactly `value` clocks in every 256.

A small register port writes and reads the sixteen values by index. Writes have no shadow copy, so a new value acts on the compare from the next clock on, even in the middle of a period.

Top module: `pwm_dac_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel value and the counter are cleared. After reset all outputs are low and `rdata` is 0.
- R2: At a clock edge where `sel` and `wr` are both high, `wdata` is stored into channel `idx`. When `sel` is low, no stored value changes.
- R3: At a clock edge where `sel` is high and `wr` is low, `rdata` takes the value stored in channel `idx`, visible after that edge. Otherwise `rdata` holds its value.
- R4: The counter is 8 bits wide and advances by one every clock. Bits 4:0 are the period position p (0 to 31). Bits 7:5 are the frame index f, which steps by one each time p wraps from 31 to 0.
- R5: For a value with coarse part M = bits 7:3, the output is high whenever p < M and low whenever p > M.
- R6: With fine part N = bits 2:0, a period is extended when N[2]=1 and f[0]=1, when N[1]=1 and f[1:0]=2'b10, or when N[0]=1 and f=3'b100. Frame index 0 is never extended.
- R7: In an extended period the output is also high at p = M. With M = 31 the output is high for all 32 clocks of that period.
- R8: Over any 256 consecutive clocks with a fixed value, the output is high for exactly 8*M + N clocks, which equals the 8-bit value.
- R9: A written value acts on the output from the clock after the write edge, even in the middle of a period.
- R10: A channel holding 0 drives a constant low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register port select |
| wr | input | 1 | Write enable (high = write, low = read) |
| idx | input | 4 | Channel index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pwm_out | output | 16 | One waveform bit per channel |

## Verification
The embedded assertions check the following on every cycle:
- the counter steps and wraps;
- the register writes land and unselected cycles leave the registers untouched;
- the registered read returns the addressed value;
- each channel is high below its coarse threshold, low above it, and low at zero.

Some properties can only be shown by the bench's scenarios. These are:
- the exact frame patterns the rate multiplier picks and the high count of 8M+N over a frame;
- a full-high period at M = 31;
- a write taking effect in mid-period.

The bench follows its own counter model cycle by cycle to show these.

// File: rtl/pwm_dac_pkg.sv
// Shared sizes for the pulse-width DAC bank.
// Assumes: channel value = {coarse part, fine part}; the fine part's width
// equals the frame-counter width.
package pwm_dac_pkg;
    localparam int NUM_CH  = 16;
    localparam int PER_W   = 5;                 // clocks per period = 2**PER_W
    localparam int FRM_W   = 3;                 // periods per frame = 2**FRM_W
    localparam int VAL_W   = PER_W + FRM_W;     // channel value width
    localparam int IDX_W   = $clog2(NUM_CH);
endpackage

// File: rtl/pwm_dac_counter.sv
// Shared free-running counter: low PER_W bits = position in period,
// high FRM_W bits = period index in frame.
// Assumes: synchronous active-low reset; no enable, it runs every clock.
module pwm_dac_counter #(
    parameter int PER_W = 5,
    parameter int FRM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PER_W-1:0] per,
    output logic [FRM_W-1:0] frame
);
    localparam int CNT_W = PER_W + FRM_W;

    logic [CNT_W-1:0] cnt_q;

    // Advance the combined counter every clock; clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign {frame, per} = cnt_q;

    // R1: reset clears the counter
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

    // R4: period wrap advances the frame index
    p_wrap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per == {PER_W{1'b1}}) |=> (per == '0 && frame == FRM_W'($past(frame) + 1'b1)));

    // R4: inside a period the frame index holds
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per != {PER_W{1'b1}}) |=> $stable(frame));
endmodule

// File: rtl/pwm_dac_regs.sv
// Register file holding one value per channel, with a registered read port.
// Assumes: a write and a read never occur in the same cycle (wr picks one);
// values act immediately, there is no shadow copy.
module pwm_dac_regs #(
    parameter int NUM_CH = 16,
    parameter int VAL_W  = 8,
    parameter int IDX_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel,
    input  logic                         wr,
    input  logic [IDX_W-1:0]             idx,
    input  logic [VAL_W-1:0]             wdata,
    output logic [VAL_W-1:0]             rdata,
    output logic [NUM_CH-1:0][VAL_W-1:0] vals
);
    // Store write data into the addressed channel; clear all in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vals <= '0;
        end else if (sel && wr) begin
            vals[idx] <= wdata;
        end
    end

    // Capture the addressed value on a read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata <= '0;
        else if (sel && !wr)   rdata <= vals[idx];
    end

    // R2: a selected write lands in the addressed register
    p_write_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> (vals[$past(idx)] == $past(wdata)));

    // R2: without a selected write no register changes
    p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(vals));

    // R3: a selected read returns the addressed value next cycle
    p_read_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> (rdata == $past(vals[idx])));

    // R3: rdata holds when no read is issued
    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |=> $stable(rdata));
endmodule

// File: rtl/pwm_dac_channel.sv
// One output channel: coarse compare against the period position, plus a
// one-clock extension in the periods the rate multiplier selects.
// Assumes: fine-part width equals frame-counter width; output is a
// combinational function of registered inputs only.
module pwm_dac_channel #(
    parameter int PER_W = 5,
    parameter int FRM_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PER_W+FRM_W-1:0] val,
    input  logic [PER_W-1:0]       per,
    input  logic [FRM_W-1:0]       frame,
    output logic                   out
);
    logic [PER_W-1:0] coarse;
    logic [FRM_W-1:0] fine;
    logic [FRM_W-1:0] pick;
    logic             ext;

    assign coarse = val[PER_W+FRM_W-1:FRM_W];
    assign fine   = val[FRM_W-1:0];

    // Fine bit FRM_W-1-j selects frames whose lowest set bit is j.
    for (genvar j = 0; j < FRM_W; j++) begin : g_pick
        if (j == 0) begin : g_lsb
            assign pick[j] = fine[FRM_W-1] && frame[0];
        end else begin : g_upper
            assign pick[j] = fine[FRM_W-1-j] && frame[j] && (frame[j-1:0] == '0);
        end
    end

    // Extension in this period if any multiplier bit selects it.
    always_comb begin
        ext = |pick;
    end

    // Drive high below the coarse threshold, and at it in extended periods.
    always_comb begin
        out = (per < coarse) || (ext && per == coarse);
    end

    // R5: high below the coarse threshold
    p_high_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per < coarse) |-> out);

    // R5: low above the coarse threshold
    p_low_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per > coarse) |-> !out);

    // R10: zero value keeps the output low
    p_zero_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (val == '0) |-> !out);

    // R6: frame index 0 is never extended
    p_frame0_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame == '0 && per == coarse) |-> !out);
endmodule

// File: rtl/pwm_dac_bank.sv
// Bank of pulse-width DAC channels sharing one counter and one register port.
// Assumes: synchronous active-low reset; channel i maps to index i.
module pwm_dac_bank
    import pwm_dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [3:0]       idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [15:0]      pwm_out
);
    logic [PER_W-1:0]             per;
    logic [FRM_W-1:0]             frame;
    logic [NUM_CH-1:0][VAL_W-1:0] vals;

    pwm_dac_counter #(.PER_W(PER_W), .FRM_W(FRM_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .per   (per),
        .frame (frame)
    );

    pwm_dac_regs #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr    (wr),
        .idx   (idx),
        .wdata (wdata),
        .rdata (rdata),
        .vals  (vals)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_dac_channel #(.PER_W(PER_W), .FRM_W(FRM_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .val   (vals[c]),
            .per   (per),
            .frame (frame),
            .out   (pwm_out[c])
        );
    end

    // R1: outputs are low in the cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0 && rdata == '0));
endmodule

// File: tb/sim_pwm_dac_bank.sv
`timescale 1ns/1ps
module sim_pwm_dac_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] pwm_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dac_bank u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .idx(idx),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    // {value, expected high clocks per 256}
    localparam logic [15:0] VEC [16] = '{
        {8'h00, 8'd0},   {8'h01, 8'd1},   {8'h04, 8'd4},   {8'h07, 8'd7},
        {8'h08, 8'd8},   {8'h0F, 8'd15},  {8'h10, 8'd16},  {8'h55, 8'd85},
        {8'h80, 8'd128}, {8'hA3, 8'd163}, {8'hF8, 8'd248}, {8'hFC, 8'd252},
        {8'hFF, 8'd255}, {8'h3A, 8'd58},  {8'hC1, 8'd193}, {8'h7E, 8'd126}
    };

    // Bench model state: its own counter and register shadow.
    logic [7:0] mcnt;
    logic [7:0] shadow [16];
    bit         cmp_en = 1'b0;
    bit         cnt_en = 1'b0;
    bit         ch_err [16];
    int         hi_cnt [16];

    always @(posedge clk) begin
        if (!rst_n) mcnt <= 8'd0;
        else        mcnt <= mcnt + 8'd1;
    end

    function automatic logic exp_bit(logic [7:0] v, logic [7:0] c);
        logic [4:0] m, p;
        logic [2:0] n, f;
        logic ext;
        m = v[7:3]; n = v[2:0]; p = c[4:0]; f = c[7:5];
        ext = (n[2] && f[0]) || (n[1] && f[1:0] == 2'b10) || (n[0] && f == 3'b100);
        return (p < m) || (ext && p == m);
    endfunction

    // Per-cycle comparison against the model and high-time counting.
    always @(negedge clk) begin
        for (int c = 0; c < 16; c++) begin
            if (cmp_en && pwm_out[c] !== exp_bit(shadow[c], mcnt)) ch_err[c] = 1'b1;
            if (cnt_en && pwm_out[c] === 1'b1) hi_cnt[c] = hi_cnt[c] + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input int i, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; idx = 4'(i); wdata = v;
        @(posedge clk);
        #1 shadow[i] = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_read(input int i, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; idx = 4'(i);
        @(negedge clk);
        v = rdata;
        sel = 1'b0;
    endtask

    task automatic clear_errs();
        for (int c = 0; c < 16; c++) begin
            ch_err[c] = 1'b0;
            hi_cnt[c] = 0;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rv;
        for (int c = 0; c < 16; c++) shadow[c] = 8'h00;
        clear_errs();

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 16'h0000, "R1 outputs low in reset", pwm_out, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(pwm_out == 16'h0000, "R1/R10 outputs low after reset", pwm_out, 0);
        check(rdata == 8'h00, "R1 rdata zero", rdata, 0);
        reg_read(9, rv);
        check(rv == 8'h00, "R1 register cleared", rv, 0);

        // Vector table: R2/R3 write and read back, R8 frame high count
        for (int k = 0; k < 16; k++) reg_write(k, VEC[k][15:8]);
        for (int k = 0; k < 16; k++) begin
            reg_read(k, rv);
            check(rv == VEC[k][15:8], "R2/R3 readback", rv, VEC[k][15:8]);
        end
        clear_errs();
        @(negedge clk);
        cmp_en = 1'b1;
        cnt_en = 1'b1;
        repeat (256) @(negedge clk);
        cnt_en = 1'b0;
        repeat (256) @(negedge clk);
        cmp_en = 1'b0;
        for (int k = 0; k < 16; k++) begin
            check(hi_cnt[k] == int'(VEC[k][7:0]), "R8 high clocks per frame",
                  hi_cnt[k], VEC[k][7:0]);
            // R4/R5/R6/R7: cycle-exact waveform against model
            check(!ch_err[k], "R4/R5/R6/R7 waveform match", ch_err[k], 0);
        end

        // R7: M=31 in an extended period stays high all 32 clocks
        reg_write(2, 8'hFC);
        while (!(mcnt == 8'h20)) @(negedge clk);  // frame 1, p = 0 (extended by N[2])
        begin
            int h = 0;
            for (int t = 0; t < 32; t++) begin
                if (pwm_out[2]) h++;
                @(negedge clk);
            end
            check(h == 32, "R7 full-high extended period", h, 32);
        end

        // R9: mid-period write acts on the next clock
        reg_write(3, 8'h10);  // M=2, N=0
        while (!(mcnt[4:0] == 5'd7)) @(negedge clk);
        check(pwm_out[3] == 1'b0, "R9 low before write", pwm_out[3], 0);
        sel = 1'b1; wr = 1'b1; idx = 4'd3; wdata = 8'hA0;  // M=20
        @(posedge clk);
        #1 shadow[3] = 8'hA0;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        check(pwm_out[3] == 1'b1, "R9 high right after mid-period write", pwm_out[3], 1);

        // R2: write without select is ignored
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; idx = 4'd3; wdata = 8'hFF;
        @(negedge clk);
        wr = 1'b0;
        reg_read(3, rv);
        check(rv == 8'hA0, "R2 unselected write ignored", rv, 8'hA0);

        // R3: rdata holds when not selected
        @(negedge clk);
        idx = 4'd0;
        repeat (3) @(negedge clk);
        check(rdata == 8'hA0, "R3 rdata holds", rdata, 8'hA0);

        // R10: zero value stays low over a full frame
        reg_write(5, 8'h00);
        clear_errs();
        cnt_en = 1'b1;
        repeat (256) @(negedge clk);
        cnt_en = 1'b0;
        check(hi_cnt[5] == 0, "R10 zero value never high", hi_cnt[5], 0);

        // R1: reset mid-run clears registers and outputs
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 16'h0000, "R1 outputs low after mid-run reset", pwm_out, 0);
        reg_read(12, rv);
        check(rv == 8'h00, "R1 register cleared by mid-run reset", rv, 0);

        done = 1'b1;
        finish_run();
    end
endmodule